// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block decodes asynchronous serial frames from one input line. It works on a sample clock enable (`sample_tick`): each tick is one sample of the line. The decoder records the sample at which a start edge arrives. Every later sample instant in the frame is measured from that edge, using a fixed-point bit width with 8 fractional bits. Because each instant is computed from the edge and not from the previous bit, a samples-per-bit value that is not a whole number does not build up error over the frame.

Several settings can change at run time: the bit width, where in the bit the line is sampled (as a percentage), the data width from 5 to 9 bits, the bit order, five parity modes, the stop length in half-bit steps (0.5, 1, 1.5 or 2 bits), and line inversion. At the end of each frame, or when a frame is aborted, the block gives a one-cycle `frame_done` pulse. With that pulse it presents the word, a valid flag, the framing-error flags, and a parity-error flag together with the expected and the received parity bit.

The control state machine has five states. IDLE waits for the start edge. START samples the start bit. DATA collects the data bits. PARITY checks the parity bit. STOP checks the stop slots. The transitions are:
- IDLE→START on the start edge.
- START→IDLE when the start bit reads high (start abort). START→DATA when it reads low.
- DATA→PARITY, or DATA→STOP when parity is off, after the last data bit.
- PARITY→STOP after the parity sample.
- STOP→IDLE on a low stop sample (stop abort) or after the last stop slot (frame end).

Top module: `uart_frame_rx`

## Requirements
- R1: During and after reset, `frame_done`, `frame_data`, `frame_valid`, `start_err`, `stop_err`, `parity_err`, `parity_expected` and `parity_actual` are all 0, and the block waits in IDLE.
- R2: A start edge is a tick at which the line (after any inversion) is 0 and the value seen at the previous tick was 1. The previous value resets to 0, so a line that is low after reset must first go high before a frame can begin.
- R3: Let the edge tick be sample 0 and let W be `cfg_bit_width` in units of 1/256 sample. Let p be `cfg_sample_pct`, replaced by 50 when it is 0 or above 99. A full slot n is sampled at sample max(1, floor((n·W + floor(W·p/100) + 128)/256)). Slot 0 is the start bit, slots 1..D are data, and then come the parity slot and the stop slots. W must be at least 4.0 samples.
- R4: The data width D is `cfg_data_bits`, clamped into the range 5..9. With `cfg_msb_first`=0 the first data slot goes to bit 0. With `cfg_msb_first`=1 it goes to bit D-1. `frame_data` bits above D-1 are 0.
- R5: `cfg_parity` sets the parity mode: 0 none, 1 odd, 2 even, 3 always 0, 4 always 1, and 5..7 act as none. Odd expects the data ones count plus the parity bit to be odd; even expects it to be even. On a mismatch, `parity_err`=1, `parity_expected` carries the bit that was wanted, and `parity_actual` carries the bit that was received.
- R6: If the start bit reads 1 at its sample point, the frame ends at once with `start_err`=1, `frame_valid`=0 and `frame_data`=0, and the block returns to IDLE.
- R7: `cfg_stop_halves` gives the stop length in half bits, from 1 to 4. A value of 0 acts as 2, and values 5..7 act as 4. Full stop slots come first. A final half slot, present when the count is odd, lasts W/2 and is sampled at floor((n·W + floor(W·p/200) + 128)/256).
- R8: On the first stop slot that reads 0, the frame ends at that sample with `stop_err`=1 and `frame_valid`=0, and any remaining stop slots are skipped.
- R9: When `cfg_invert`=1 the line is complemented before any decoding, so an idle-low line with a rising edge starts a frame.
- R10: `frame_done` is high for exactly one cycle, the cycle after the tick that carried the frame's last sample. The result outputs change only together with `frame_done` and hold until the next pulse.
- R11: `frame_valid` is 1 exactly when none of `start_err`, `stop_err` and `parity_err` is set for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_tick | input | 1 | One line sample per high cycle |
| rx_line | input | 1 | Serial input, already synchronized |
| cfg_bit_width | input | 20 | Samples per bit, 12.8 fixed point |
| cfg_sample_pct | input | 7 | Sample point within the bit, in percent |
| cfg_data_bits | input | 4 | Data bits per frame |
| cfg_msb_first | input | 1 | 1: first data bit is the MSB |
| cfg_parity | input | 3 | Parity mode code |
| cfg_stop_halves | input | 3 | Stop length in half bits |
| cfg_invert | input | 1 | Complement the line |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| frame_data | output | 9 | Received word |
| frame_valid | output | 1 | Frame had no error |
| start_err | output | 1 | Start bit read high |
| stop_err | output | 1 | A stop bit read low |
| parity_err | output | 1 | Parity mismatch |
| parity_expected | output | 1 | Parity bit that was expected |
| parity_actual | output | 1 | Parity bit that was received |

## Verification
A wrong slot accumulator or wrong sample-point offset moves the sample instant. Within the same frame this shows up in one of two ways: `frame_done` arrives at a different tick, or a data bit is taken from the neighbouring slot, which corrupts `frame_data`. A wrong state sequence shows up as a word that is too short or too long, as a missing parity check, or as an abort at the wrong slot, and in each case the `frame_done` tick is off. Every frame is therefore checked for the exact tick of its pulse as well as for its contents. Bit-width, percentage, width, order, parity, stop and inversion settings are drawn at random, alongside directed cases for the percentage fallback, the one-sample minimum and the half stop slots.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int unsigned FRAC_W   = 8;
    localparam int unsigned ROUND_Q  = 128;
    localparam int unsigned PCT_DFLT = 50;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    typedef enum logic [2:0] {
        PAR_NONE = 3'd0,
        PAR_ODD  = 3'd1,
        PAR_EVEN = 3'd2,
        PAR_ZERO = 3'd3,
        PAR_ONE  = 3'd4
    } par_mode_t;

    function automatic logic par_enabled(input logic [2:0] mode);
        return (mode >= 3'd1) && (mode <= 3'd4);
    endfunction

    // Parity bit the sender should have placed after the given word.
    function automatic logic par_wanted(input logic [2:0] mode, input logic [8:0] word);
        logic res;
        unique case (mode)
            PAR_ODD:  res = ~(^word);
            PAR_EVEN: res = ^word;
            PAR_ONE:  res = 1'b1;
            default:  res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/uart_rx_timing.sv
// Sample-point offsets derived from the bit width and the percentage.
module uart_rx_timing #(
    parameter int WQ = 20,
    localparam int PW = WQ + 7
) (
    input  logic [WQ-1:0] cfg_bit_width,
    input  logic [6:0]    cfg_sample_pct,
    output logic [PW-1:0] off_full,
    output logic [PW-1:0] off_half
);
    import uart_rx_pkg::*;

    localparam logic [PW-1:0] DIV_FULL = PW'(100);
    localparam logic [PW-1:0] DIV_HALF = PW'(200);

    logic [6:0]    pct_eff;
    logic [PW-1:0] prod;

    always_comb begin
        if ((cfg_sample_pct == 7'd0) || (cfg_sample_pct > 7'd99)) begin
            pct_eff = 7'(PCT_DFLT);
        end else begin
            pct_eff = cfg_sample_pct;
        end
        prod     = PW'(cfg_bit_width) * PW'(pct_eff);
        off_full = prod / DIV_FULL;
        off_half = prod / DIV_HALF;
    end

endmodule

// File: rtl/uart_rx_slot_timer.sv
// Counts samples since the start edge and fires at each slot's sample point.
module uart_rx_slot_timer #(
    parameter int WQ = 20,
    localparam int ACC_W = WQ + 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic             active,
    input  logic             half_slot,
    input  logic [WQ-1:0]    bit_width,
    input  logic [ACC_W-1:0] off_full,
    input  logic [ACC_W-1:0] off_half,
    output logic             hit
);
    import uart_rx_pkg::*;

    logic [ACC_W-1:0] begin_q;
    logic [ACC_W:0]   cnt_q;
    logic [ACC_W:0]   cnt_inc;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   tgt;
    logic [ACC_W:0]   tgt_eff;

    always_comb begin
        sum     = {1'b0, begin_q} + {1'b0, (half_slot ? off_half : off_full)}
                + (ACC_W+1)'(ROUND_Q);
        tgt     = sum >> FRAC_W;
        tgt_eff = (tgt == '0) ? (ACC_W+1)'(1) : tgt;
        cnt_inc = cnt_q + (ACC_W+1)'(1);
        hit     = tick && active && (cnt_inc >= tgt_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            begin_q <= '0;
        end else if (clear) begin
            cnt_q   <= '0;
            begin_q <= '0;
        end else if (tick && active) begin
            cnt_q <= cnt_inc;
            if (hit) begin
                begin_q <= begin_q + ACC_W'(bit_width);
            end
        end
    end

    // Bit width of at least four samples keeps sample points apart.
    AST_HIT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit); // R3

endmodule

// File: rtl/uart_rx_word.sv
// Places each received data bit at its position in the word.
module uart_rx_word #(
    parameter int MAX_DATA = 9,
    localparam int IDX_W = $clog2(MAX_DATA + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                load,
    input  logic                bit_in,
    input  logic [IDX_W-1:0]    idx,
    input  logic [IDX_W-1:0]    nbits,
    input  logic                msb_first,
    output logic [MAX_DATA-1:0] word
);
    logic [IDX_W-1:0] pos;

    always_comb begin
        if (msb_first) begin
            pos = nbits - IDX_W'(1) - idx;
        end else begin
            pos = idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clear) begin
            word <= '0;
        end else if (load && (pos < IDX_W'(MAX_DATA))) begin
            word[pos] <= bit_in;
        end
    end

    AST_LOAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (idx < nbits)); // R4

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
    parameter int SPB_INT_W = 12,
    parameter int MAX_DATA  = 9,
    localparam int WQ    = SPB_INT_W + uart_rx_pkg::FRAC_W,
    localparam int ACC_W = WQ + 7,
    localparam int IDX_W = $clog2(MAX_DATA + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_tick,
    input  logic                rx_line,
    input  logic [WQ-1:0]       cfg_bit_width,
    input  logic [6:0]          cfg_sample_pct,
    input  logic [IDX_W-1:0]    cfg_data_bits,
    input  logic                cfg_msb_first,
    input  logic [2:0]          cfg_parity,
    input  logic [2:0]          cfg_stop_halves,
    input  logic                cfg_invert,
    output logic                frame_done,
    output logic [MAX_DATA-1:0] frame_data,
    output logic                frame_valid,
    output logic                start_err,
    output logic                stop_err,
    output logic                parity_err,
    output logic                parity_expected,
    output logic                parity_actual
);
    import uart_rx_pkg::*;

    localparam logic [IDX_W-1:0] MIN_BITS = IDX_W'(5);
    localparam logic [IDX_W-1:0] MAX_BITS = IDX_W'(MAX_DATA);

    rx_state_t        state_q, state_d;
    logic             line_i;
    logic             prev_q;
    logic             start_det;
    logic             hit;
    logic             half_slot;
    logic [IDX_W-1:0] nbits_eff;
    logic [2:0]       stop_eff;
    logic [IDX_W-1:0] bit_idx_q;
    logic [2:0]       stop_left_q;
    logic             par_bad_q, par_exp_q, par_act_q;
    logic             last_data;
    logic             par_on;
    logic             par_want;
    logic             end_ok, abort_start, abort_stop, done_d;
    logic [ACC_W-1:0] off_full, off_half;
    logic [MAX_DATA-1:0] word;

    // Settings after clamping and inversion
    always_comb begin
        line_i = rx_line ^ cfg_invert;
        if (cfg_data_bits < MIN_BITS) begin
            nbits_eff = MIN_BITS;
        end else if (cfg_data_bits > MAX_BITS) begin
            nbits_eff = MAX_BITS;
        end else begin
            nbits_eff = cfg_data_bits;
        end
        if (cfg_stop_halves == 3'd0) begin
            stop_eff = 3'd2;
        end else if (cfg_stop_halves > 3'd4) begin
            stop_eff = 3'd4;
        end else begin
            stop_eff = cfg_stop_halves;
        end
        par_on    = par_enabled(cfg_parity);
        par_want  = par_wanted(cfg_parity, 9'(word));
        start_det = sample_tick && (state_q == ST_IDLE) && prev_q && !line_i;
        half_slot = (state_q == ST_STOP) && (stop_left_q == 3'd1);
        last_data = (bit_idx_q == nbits_eff - IDX_W'(1));
    end

    uart_rx_timing #(.WQ(WQ)) timing_i (
        .cfg_bit_width (cfg_bit_width),
        .cfg_sample_pct(cfg_sample_pct),
        .off_full      (off_full),
        .off_half      (off_half)
    );

    uart_rx_slot_timer #(.WQ(WQ)) slot_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_tick),
        .clear    (start_det),
        .active   (state_q != ST_IDLE),
        .half_slot(half_slot),
        .bit_width(cfg_bit_width),
        .off_full (off_full),
        .off_half (off_half),
        .hit      (hit)
    );

    uart_rx_word #(.MAX_DATA(MAX_DATA)) word_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_det),
        .load     ((state_q == ST_DATA) && hit),
        .bit_in   (line_i),
        .idx      (bit_idx_q),
        .nbits    (nbits_eff),
        .msb_first(cfg_msb_first),
        .word     (word)
    );

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        end_ok      = 1'b0;
        abort_start = 1'b0;
        abort_stop  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_det) state_d = ST_START;
            end
            ST_START: begin
                if (hit) begin
                    if (line_i) begin
                        abort_start = 1'b1;
                        state_d     = ST_IDLE;
                    end else begin
                        state_d = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (hit && last_data) state_d = par_on ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (hit) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (hit) begin
                    if (!line_i) begin
                        abort_stop = 1'b1;
                        state_d    = ST_IDLE;
                    end else if (stop_left_q <= 3'd2) begin
                        end_ok  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        done_d = end_ok || abort_start || abort_stop;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Frame bookkeeping: edge history, slot indices, parity capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q      <= 1'b0;
            bit_idx_q   <= '0;
            stop_left_q <= '0;
            par_bad_q   <= 1'b0;
            par_exp_q   <= 1'b0;
            par_act_q   <= 1'b0;
        end else begin
            if (sample_tick) prev_q <= line_i;
            if (start_det) begin
                bit_idx_q   <= '0;
                stop_left_q <= stop_eff;
                par_bad_q   <= 1'b0;
                par_exp_q   <= 1'b0;
                par_act_q   <= 1'b0;
            end else if (hit) begin
                if (state_q == ST_DATA) begin
                    bit_idx_q <= bit_idx_q + IDX_W'(1);
                end
                if (state_q == ST_PARITY) begin
                    par_exp_q <= par_want;
                    par_act_q <= line_i;
                    par_bad_q <= (line_i != par_want);
                end
                if ((state_q == ST_STOP) && (stop_left_q >= 3'd2)) begin
                    stop_left_q <= stop_left_q - 3'd2;
                end
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_done      <= 1'b0;
            frame_data      <= '0;
            frame_valid     <= 1'b0;
            start_err       <= 1'b0;
            stop_err        <= 1'b0;
            parity_err      <= 1'b0;
            parity_expected <= 1'b0;
            parity_actual   <= 1'b0;
        end else begin
            frame_done <= done_d;
            if (done_d) begin
                frame_data      <= word;
                frame_valid     <= !(abort_start || abort_stop || par_bad_q);
                start_err       <= abort_start;
                stop_err        <= abort_stop;
                parity_err      <= par_bad_q;
                parity_expected <= par_exp_q;
                parity_actual   <= par_act_q;
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R10
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable(frame_data)); // R10
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (state_q == ST_IDLE)); // R10
    AST_PAR_PAIR_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && parity_err) |-> (parity_expected != parity_actual)); // R5
    AST_SINGLE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !(start_err && stop_err)); // R8
    AST_VALID_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (frame_valid == !(start_err || stop_err || parity_err))); // R11
    AST_START_ABORT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && start_err) |-> (frame_data == '0)); // R6

endmodule

// File: tb/uart_frame_rx_tb_top.sv
module uart_frame_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rx_line = 1'b0;
    logic [19:0] cfg_bit_width = 20'd2560;
    logic [6:0] cfg_sample_pct = 7'd50;
    logic [3:0] cfg_data_bits = 4'd8;
    logic       cfg_msb_first = 1'b0;
    logic [2:0] cfg_parity = 3'd0;
    logic [2:0] cfg_stop_halves = 3'd2;
    logic       cfg_invert = 1'b0;

    logic       frame_done;
    logic [8:0] frame_data;
    logic       frame_valid, start_err, stop_err, parity_err, parity_expected, parity_actual;

    int checks = 0;
    int fails = 0;
    int samp_idx = 0;
    int done_cnt = 0;
    int done_at = 0;
    logic [8:0] cap_data;
    logic cap_valid, cap_serr, cap_perr_stop, cap_perr, cap_pexp, cap_pact;

    uart_frame_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
        .cfg_bit_width(cfg_bit_width), .cfg_sample_pct(cfg_sample_pct),
        .cfg_data_bits(cfg_data_bits), .cfg_msb_first(cfg_msb_first),
        .cfg_parity(cfg_parity), .cfg_stop_halves(cfg_stop_halves),
        .cfg_invert(cfg_invert),
        .frame_done(frame_done), .frame_data(frame_data), .frame_valid(frame_valid),
        .start_err(start_err), .stop_err(stop_err), .parity_err(parity_err),
        .parity_expected(parity_expected), .parity_actual(parity_actual)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint pct_eff();
        return (cfg_sample_pct == 0 || cfg_sample_pct > 99) ? 50 : longint'(cfg_sample_pct);
    endfunction

    function automatic longint samp_off(input int n, input bit half);
        longint w = longint'(cfg_bit_width);
        longint off = half ? (w * pct_eff()) / 200 : (w * pct_eff()) / 100;
        longint t = (longint'(n) * w + off + 128) / 256;
        return (t == 0) ? 1 : t;
    endfunction

    function automatic longint slot_beg(input int n);
        return (longint'(n) * longint'(cfg_bit_width) + 128) / 256;
    endfunction

    function automatic int nb_eff();
        return (cfg_data_bits < 5) ? 5 : (cfg_data_bits > 9) ? 9 : int'(cfg_data_bits);
    endfunction

    function automatic int sh_eff();
        return (cfg_stop_halves == 0) ? 2 : (cfg_stop_halves > 4) ? 4 : int'(cfg_stop_halves);
    endfunction

    function automatic logic par_of(input logic [8:0] d, input int nb);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        case (cfg_parity)
            3'd1: return (ones % 2 == 0);
            3'd2: return (ones % 2 == 1);
            3'd4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_sample(input logic lvl);
        @(negedge clk);
        rx_line = lvl ^ cfg_invert;
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        if (frame_done) begin
            done_cnt++;
            done_at = samp_idx;
            cap_data = frame_data; cap_valid = frame_valid; cap_serr = start_err;
            cap_perr_stop = stop_err; cap_perr = parity_err;
            cap_pexp = parity_expected; cap_pact = parity_actual;
        end
        samp_idx++;
    endtask

    task automatic set_cfg(input int wq, input int pct, input int nb, input bit msb,
                           input int par, input int sh, input bit inv);
        @(negedge clk);
        cfg_bit_width = 20'(wq); cfg_sample_pct = 7'(pct); cfg_data_bits = 4'(nb);
        cfg_msb_first = msb; cfg_parity = 3'(par); cfg_stop_halves = 3'(sh);
        cfg_invert = inv; rx_line = ~inv;
    endtask

    // inject: 0 clean, 1 start glitch, 2 first stop low, 3 parity flipped
    task automatic send_frame(input logic [8:0] data, input int inject, input string tag);
        logic lv [0:15];
        int nb = nb_eff();
        int sh = sh_eff();
        bit pe = (cfg_parity >= 1 && cfg_parity <= 4);
        int idx, first_stop, nslots, e;
        bit half_last;
        longint flen, exp_off;
        logic [8:0] mask;
        lv[0] = 1'b0;
        for (int j = 0; j < nb; j++) lv[1+j] = cfg_msb_first ? data[nb-1-j] : data[j];
        idx = 1 + nb;
        if (pe) begin
            lv[idx] = par_of(data, nb) ^ (inject == 3);
            idx++;
        end
        first_stop = idx;
        half_last = (sh % 2 == 1);
        nslots = idx + sh / 2 + (half_last ? 1 : 0);
        for (int k = idx; k < nslots; k++) lv[k] = 1'b1;
        if (inject == 2) lv[first_stop] = 1'b0;
        for (int i = 0; i < 3; i++) do_sample(1'b1);
        e = samp_idx;
        done_cnt = 0;
        flen = half_last ? (longint'(nslots - 1) * longint'(cfg_bit_width)
                            + longint'(cfg_bit_width) / 2 + 128) / 256
                         : slot_beg(nslots);
        for (longint s = 0; s < flen; s++) begin
            int k = 0;
            while (k + 1 < nslots && slot_beg(k + 1) <= s) k++;
            if (inject == 1) do_sample(s == 0 ? 1'b0 : 1'b1);
            else do_sample(lv[k]);
        end
        for (int i = 0; i < 2; i++) do_sample(1'b1);
        if (inject == 1) exp_off = samp_off(0, 1'b0);
        else if (inject == 2) exp_off = samp_off(first_stop, 1'b0);
        else exp_off = samp_off(nslots - 1, half_last);
        mask = 9'((1 << nb) - 1);
        chk("R10", {tag, " done pulses"}, done_cnt, 1);
        chk("R3", {tag, " done sample"}, done_at - e, exp_off);
        chk("R6", {tag, " start_err"}, cap_serr, inject == 1);
        chk("R8", {tag, " stop_err"}, cap_perr_stop, inject == 2);
        chk("R5", {tag, " parity_err"}, cap_perr, inject == 3);
        chk("R11", {tag, " valid"}, cap_valid, inject == 0);
        if (inject == 1) chk("R6", {tag, " data"}, cap_data, 0);
        else chk(cfg_invert ? "R9" : "R4", {tag, " data"}, cap_data, data & mask);
        if (inject == 3) begin
            chk("R5", {tag, " expected bit"}, cap_pexp, par_of(data, nb));
            chk("R5", {tag, " received bit"}, cap_pact, !par_of(data, nb));
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "done in reset", frame_done, 0);
        chk("R1", "outputs in reset",
            {frame_data, frame_valid, start_err, stop_err, parity_err,
             parity_expected, parity_actual}, 0);
        rst_n = 1'b1;
        // R2: low line after reset, no frame
        done_cnt = 0;
        for (int i = 0; i < 40; i++) do_sample(1'b0);
        chk("R2", "no frame from low line after reset", done_cnt, 0);

        set_cfg(2560, 50, 8, 0, 0, 2, 0);  send_frame(9'h05A, 0, "8N1");
        set_cfg(2560, 50, 8, 1, 2, 2, 0);  send_frame(9'h0C3, 0, "msb even");
        set_cfg(2304, 50, 5, 0, 1, 2, 0);  send_frame(9'h013, 0, "5 odd");
        set_cfg(3000, 40, 9, 0, 4, 4, 0);  send_frame(9'h1A5, 0, "9 one 2stop");
        set_cfg(2048, 1, 8, 0, 0, 2, 0);   send_frame(9'h03C, 0, "pct1 R3");
        set_cfg(3200, 0, 7, 0, 0, 2, 0);   send_frame(9'h055, 0, "pct0 fallback R3");
        set_cfg(3200, 120, 7, 1, 2, 2, 0); send_frame(9'h02B, 0, "pct120 fallback R3");
        set_cfg(2560, 50, 8, 0, 3, 1, 0);  send_frame(9'h0F0, 0, "half stop R7");
        set_cfg(2560, 70, 8, 0, 0, 3, 0);  send_frame(9'h081, 0, "1.5 stop R7");
        set_cfg(2560, 50, 8, 0, 0, 0, 0);  send_frame(9'h011, 0, "stop code0 R7");
        set_cfg(2560, 50, 8, 0, 0, 7, 0);  send_frame(9'h022, 2, "stop code7 R7");
        set_cfg(2560, 50, 8, 0, 0, 2, 0);  send_frame(9'h000, 1, "start glitch R6");
        set_cfg(2560, 50, 8, 0, 2, 4, 0);  send_frame(9'h0A7, 2, "stop abort R8");
        set_cfg(2560, 50, 8, 0, 1, 2, 0);  send_frame(9'h0B4, 3, "odd flip R5");
        set_cfg(2560, 50, 8, 0, 3, 2, 0);  send_frame(9'h0B4, 3, "zero flip R5");
        set_cfg(2816, 50, 8, 1, 2, 2, 1);  send_frame(9'h069, 0, "inverted R9");
        set_cfg(2560, 50, 3, 0, 0, 2, 0);  send_frame(9'h1FF, 0, "width clamp low R4");
        set_cfg(2560, 50, 14, 0, 0, 2, 0); send_frame(9'h1C7, 0, "width clamp high R4");

        for (int f = 0; f < 40; f++) begin
            int wq = int'($urandom_range(16 * 256, 5 * 256));
            int pr = int'($urandom_range(9, 0));
            int pct = (pr == 0) ? 0 : (pr == 1) ? 110 : int'($urandom_range(80, 20));
            int nb = int'($urandom_range(9, 5));
            int par = int'($urandom_range(4, 0));
            int sh = int'($urandom_range(4, 1));
            int inj = int'($urandom_range(3, 0));
            if (inj == 2 && sh < 2) inj = 0;
            if (inj == 3 && par == 0) inj = 0;
            set_cfg(wq, pct, nb, 1'($urandom_range(1, 0)), par, sh, 1'($urandom_range(1, 0)));
            send_frame(9'($urandom), inj, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule